// File: doc/BRIEF.md
# Four-Way Set-Associative Cache Directory

This block is the tag and replacement directory of a 16 KB unified cache built as four ways of 256 sets with 16-byte lines. For every lookup it takes a 32-bit physical address and selects a set with address bits 11..4. It then compares the stored tags of all four ways and reports, one clock later, whether the line is present, which way holds it and whether that line has been written. On a miss it names the way to replace. If that way holds a modified line, it also asks for the old line to be written back and gives the old tag and set.

The stored tag is physical address bits 31..10, so it overlaps the two upper index bits. The three top address bits are alias bits that select no different memory. They are stored and compared as zero. Valid and dirty flags are kept in flops that a power-on reset clears. A manual reset only quiets the response outputs and leaves every directory entry as it was. The tag storage has no reset. Each set keeps a 6-bit pairwise age code that ranks its four ways. The data array, the bus side and the refill sequence belong to the surrounding controller, which drives line fills into the directory through a separate port.

Top module: `cache_dir4`

## Requirements
- R1: After power-on reset (`por_rst_n` low at a clock edge) all response outputs are 0 and every entry of every way is invalid, so the first lookup of any address misses.
- R2: A request is taken at a clock edge when `req_valid` is 1, `req_op` is not 2'b11 and `fill_valid` is 0. The `req_op` codes are: 2'b00 read, 2'b01 write, 2'b10 invalidate. The response appears after that edge with `rsp_valid` = 1. In any other cycle `rsp_valid` is 0 in the following cycle. A request made together with a fill has no effect.
- R3: A hit needs the valid bit set and the stored tag equal to the request tag in the set selected by address bits 11..4. `rsp_way` then gives the matching way, and at most one way can match.
- R4: A write hit sets the line's dirty bit when `wb_mode` is 1 and leaves it unchanged when `wb_mode` is 0. `rsp_dirty` reports the dirty bit of the hit line as it stood before the request, and is 0 on a miss.
- R5: A fill (`fill_valid` with `fill_addr` and `fill_way`) stores the tag in that way of the addressed set, sets valid, clears dirty and makes that way the most recently used of the set.
- R6: The replacement way is the lowest-numbered invalid way of the set. If all four ways are valid, it is the least recently used way. Read hits, write hits and fills update the recency order. Misses and invalidates leave it unchanged. After power-on reset the order ranks way 3 oldest and way 0 newest.
- R7: A read or write miss gives `fill_req` = 1 and `rsp_way` = the replacement way. When that way is valid and dirty, `wb_req` = 1, `wb_tag` = its stored tag and `wb_index` = the set. Otherwise `wb_req` = 0.
- R8: An invalidate that hits clears the valid and dirty bits of the matching way and reports `rsp_hit` = 1 with that way. An invalidate that misses changes nothing and reports `rsp_way` = 0. An invalidate never raises `fill_req` or `wb_req`.
- R9: While `man_rst_n` is low, the response outputs clear and no request or fill changes the directory. Valid bits, dirty bits, tags and recency state keep their values through the manual reset.
- R10: Address bits 31..29 are ignored. Two addresses that differ only in those bits hit the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Power-on reset, synchronous, active low |
| man_rst_n | input | 1 | Manual reset, synchronous, active low, keeps directory contents |
| wb_mode | input | 1 | 1 = write-back (write hits mark the line dirty), 0 = write-through |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00 read, 01 write, 10 invalidate, 11 none |
| req_addr | input | 32 | Physical address of the request |
| fill_valid | input | 1 | Line fill strobe |
| fill_addr | input | 32 | Physical address of the filled line |
| fill_way | input | 2 | Way that receives the fill |
| rsp_valid | output | 1 | Response present for the request of the previous cycle |
| rsp_hit | output | 1 | Tag matched in a valid way |
| rsp_way | output | 2 | Hit way, or replacement way on a read/write miss |
| rsp_dirty | output | 1 | Dirty bit of the hit line before the request |
| fill_req | output | 1 | Read/write miss: the line must be fetched |
| wb_req | output | 1 | Replacement way holds a modified line to write back |
| wb_tag | output | 22 | Tag of the line to write back |
| wb_index | output | 8 | Set of the line to write back |

## Verification
All lookup results are due exactly one clock after the edge that takes the request. Directory updates from that edge, such as dirty marking, invalidation, recency and fills, show up in the response to a request made at the next edge or later. The bench changes inputs on the falling edge, lets one rising edge pass, and samples the outputs on the following falling edge. Each check therefore reads the registered result of exactly one request. State effects are observed through the response to a later request, and a fill is issued as a separate cycle before the lookup that should see it.

// File: rtl/cdir_pkg.sv
// Package: shared constants, request codes and the pairwise age (LRU)
// helpers of the four-way directory.
// Assumes exactly four ways; the 6-bit age code is defined for four ways only.
package cdir_pkg;

    localparam int WAYS  = 4;
    localparam int WAY_W = 2;
    localparam int AGE_W = 6;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_INVAL = 2'b10,
        OP_NONE  = 2'b11
    } dir_op_e;

    typedef logic [AGE_W-1:0] age_t;

    // Age bit k covers one way pair: 0:(0,1) 1:(0,2) 2:(0,3) 3:(1,2) 4:(1,3) 5:(2,3).
    // A 1 means the lower-numbered way of the pair is the older one.
    function automatic age_t age_touch(age_t cur, logic [WAY_W-1:0] w);
        age_t nxt;
        nxt = cur;
        case (w)
            2'd0: begin nxt[0] = 1'b0; nxt[1] = 1'b0; nxt[2] = 1'b0; end
            2'd1: begin nxt[0] = 1'b1; nxt[3] = 1'b0; nxt[4] = 1'b0; end
            2'd2: begin nxt[1] = 1'b1; nxt[3] = 1'b1; nxt[5] = 1'b0; end
            default: begin nxt[2] = 1'b1; nxt[4] = 1'b1; nxt[5] = 1'b1; end
        endcase
        return nxt;
    endfunction

    // Returns the way older than all three others.
    function automatic logic [WAY_W-1:0] age_oldest(age_t s);
        logic [WAY_W-1:0] w;
        if (s[0] && s[1] && s[2])
            w = 2'd0;
        else if (!s[0] && s[3] && s[4])
            w = 2'd1;
        else if (!s[1] && !s[3] && s[5])
            w = 2'd2;
        else
            w = 2'd3;
        return w;
    endfunction

endpackage

// File: rtl/cdir_way.sv
// One way of the directory: tag storage without reset, plus valid and
// dirty flags per set that only the power-on reset clears.
// Assumes the caller never asserts fill_en together with set_dirty_en or
// inval_en (the top module blocks requests in fill cycles).
module cdir_way
    import cdir_pkg::*;
#(
    parameter int SETS  = 256,
    parameter int IDX_W = 8,
    parameter int TAG_W = 22
) (
    input  logic             clk,
    input  logic             por_rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] cmp_tag,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             set_dirty_en,
    input  logic             inval_en,
    output logic             hit,
    output logic             ent_valid,
    output logic             ent_dirty,
    output logic [TAG_W-1:0] ent_tag
);

    logic [TAG_W-1:0] tag_mem [SETS];
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;

    // Tag write on fill; deliberately no reset.
    always_ff @(posedge clk) begin
        if (fill_en)
            tag_mem[fill_idx] <= fill_tag;
    end

    // Valid/dirty maintenance: power-on clear, fill, invalidate, write mark.
    always_ff @(posedge clk) begin
        if (!por_rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[fill_idx] <= 1'b1;
            dirty_q[fill_idx] <= 1'b0;
        end else if (inval_en) begin
            valid_q[rd_idx] <= 1'b0;
            dirty_q[rd_idx] <= 1'b0;
        end else if (set_dirty_en) begin
            dirty_q[rd_idx] <= 1'b1;
        end
    end

    // Read port and tag compare for the selected set.
    always_comb begin
        ent_valid = valid_q[rd_idx];
        ent_dirty = dirty_q[rd_idx];
        ent_tag   = tag_mem[rd_idx];
        hit       = ent_valid && (ent_tag == cmp_tag);
    end

endmodule

// File: rtl/cdir_age.sv
// Per-set 6-bit pairwise age state. Cleared by power-on reset only.
// Assumes at most one update per cycle.
module cdir_age
    import cdir_pkg::*;
#(
    parameter int SETS  = 256,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             por_rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [WAY_W-1:0] upd_way,
    output age_t             rd_age
);

    age_t age_q [SETS];

    // Age update: accessed way becomes most recently used.
    always_ff @(posedge clk) begin
        if (!por_rst_n) begin
            for (int s = 0; s < SETS; s++)
                age_q[s] <= '0;
        end else if (upd_en) begin
            age_q[upd_idx] <= age_touch(age_q[upd_idx], upd_way);
        end
    end

    // Read port for the looked-up set.
    assign rd_age = age_q[rd_idx];

endmodule

// File: rtl/cdir_victim.sv
// Replacement choice: lowest invalid way, else the oldest way by age code.
// Assumes the age code holds a consistent total order (kept by age_touch).
module cdir_victim
    import cdir_pkg::*;
(
    input  logic [WAYS-1:0]  way_valid,
    input  age_t             set_age,
    output logic [WAY_W-1:0] victim
);

    // Priority scan over invalid ways, falling back to the age order.
    always_comb begin
        victim = age_oldest(set_age);
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w])
                victim = WAY_W'(w);
        end
    end

endmodule

// File: rtl/cache_dir4.sv
// Top of the four-way directory. Decodes a request, compares the selected
// set in all ways, registers the result for the next cycle and schedules
// dirty marking, invalidation, age update and fills.
// Assumes: fills never target a line already present in another way;
// a request issued in a fill cycle is dropped.
module cache_dir4
    import cdir_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SETS        = 256,
    parameter int LINE_BYTES  = 16,
    parameter int TAG_LSB     = 10,
    parameter int SHADOW_BITS = 3
) (
    input  logic                           clk,
    input  logic                           por_rst_n,
    input  logic                           man_rst_n,
    input  logic                           wb_mode,
    input  logic                           req_valid,
    input  logic [1:0]                     req_op,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic                           fill_valid,
    input  logic [ADDR_W-1:0]              fill_addr,
    input  logic [1:0]                     fill_way,
    output logic                           rsp_valid,
    output logic                           rsp_hit,
    output logic [1:0]                     rsp_way,
    output logic                           rsp_dirty,
    output logic                           fill_req,
    output logic                           wb_req,
    output logic [ADDR_W-TAG_LSB-1:0]      wb_tag,
    output logic [$clog2(SETS)-1:0]        wb_index
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - TAG_LSB;

    // Request decode
    logic             active;
    logic             acc;
    logic             is_inval;
    logic             is_write;
    logic [IDX_W-1:0] req_idx;
    logic [IDX_W-1:0] fil_idx;
    logic [TAG_W-1:0] req_tag;
    logic [TAG_W-1:0] fil_tag;
    logic             unused_bits;

    // Per-way results
    logic [WAYS-1:0]  hit_vec;
    logic [WAYS-1:0]  vld_vec;
    logic [WAYS-1:0]  drt_vec;
    logic [TAG_W-1:0] way_tag [WAYS];
    logic             any_hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] victim;
    age_t             set_age;
    logic             age_upd;
    logic [IDX_W-1:0] age_idx;
    logic [WAY_W-1:0] age_way;

    // Address split and tag forming, alias bits forced to zero.
    always_comb begin
        req_idx = req_addr[OFF_W+IDX_W-1:OFF_W];
        fil_idx = fill_addr[OFF_W+IDX_W-1:OFF_W];
        req_tag = req_addr[ADDR_W-1:TAG_LSB];
        fil_tag = fill_addr[ADDR_W-1:TAG_LSB];
        req_tag[TAG_W-1 -: SHADOW_BITS] = '0;
        fil_tag[TAG_W-1 -: SHADOW_BITS] = '0;
    end

    assign unused_bits = ^{req_addr[OFF_W-1:0], fill_addr[OFF_W-1:0],
                           req_addr[ADDR_W-1 -: SHADOW_BITS],
                           fill_addr[ADDR_W-1 -: SHADOW_BITS]};

    // Request acceptance: both resets released, no fill in the same cycle.
    always_comb begin
        active   = por_rst_n && man_rst_n;
        acc      = active && req_valid && !fill_valid && (req_op != OP_NONE);
        is_inval = (req_op == OP_INVAL);
        is_write = (req_op == OP_WRITE);
    end

    // Way instances
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic fill_here;
        logic mark_here;
        logic kill_here;

        assign fill_here = active && fill_valid && (fill_way == WAY_W'(w));
        assign mark_here = acc && is_write && wb_mode && hit_vec[w];
        assign kill_here = acc && is_inval && hit_vec[w];

        cdir_way #(
            .SETS  (SETS),
            .IDX_W (IDX_W),
            .TAG_W (TAG_W)
        ) way_i (
            .clk          (clk),
            .por_rst_n    (por_rst_n),
            .rd_idx       (req_idx),
            .cmp_tag      (req_tag),
            .fill_en      (fill_here),
            .fill_idx     (fil_idx),
            .fill_tag     (fil_tag),
            .set_dirty_en (mark_here),
            .inval_en     (kill_here),
            .hit          (hit_vec[w]),
            .ent_valid    (vld_vec[w]),
            .ent_dirty    (drt_vec[w]),
            .ent_tag      (way_tag[w])
        );
    end

    // Hit way encoding.
    always_comb begin
        any_hit = |hit_vec;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w])
                hit_way = WAY_W'(w);
        end
    end

    // Age update source: fill takes the port, else a read/write hit.
    always_comb begin
        age_upd = (active && fill_valid) || (acc && any_hit && !is_inval);
        age_idx = fill_valid ? fil_idx : req_idx;
        age_way = fill_valid ? fill_way : hit_way;
    end

    cdir_age #(
        .SETS  (SETS),
        .IDX_W (IDX_W)
    ) age_i (
        .clk       (clk),
        .por_rst_n (por_rst_n),
        .rd_idx    (req_idx),
        .upd_en    (age_upd),
        .upd_idx   (age_idx),
        .upd_way   (age_way),
        .rd_age    (set_age)
    );

    cdir_victim victim_i (
        .way_valid (vld_vec),
        .set_age   (set_age),
        .victim    (victim)
    );

    // Registered response; either reset clears it.
    always_ff @(posedge clk) begin
        if (!por_rst_n || !man_rst_n || !acc) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_way   <= '0;
            rsp_dirty <= 1'b0;
            fill_req  <= 1'b0;
            wb_req    <= 1'b0;
            wb_tag    <= '0;
            wb_index  <= '0;
        end else begin
            rsp_valid <= 1'b1;
            rsp_hit   <= any_hit;
            rsp_dirty <= any_hit && drt_vec[hit_way];
            if (any_hit)
                rsp_way <= hit_way;
            else if (is_inval)
                rsp_way <= '0;
            else
                rsp_way <= victim;
            fill_req <= !any_hit && !is_inval;
            if (!any_hit && !is_inval && vld_vec[victim] && drt_vec[victim]) begin
                wb_req   <= 1'b1;
                wb_tag   <= way_tag[victim];
                wb_index <= req_idx;
            end else begin
                wb_req   <= 1'b0;
                wb_tag   <= '0;
                wb_index <= '0;
            end
        end
    end

endmodule

// File: rtl/cache_dir4_chk.sv
// Checker bound to cache_dir4: temporal properties on its ports and on
// signals driven by separate sub-blocks.
module cache_dir4_chk #(
    parameter int IDX_W = 8,
    parameter int OFF_W = 4
) (
    input logic             clk,
    input logic             por_rst_n,
    input logic             man_rst_n,
    input logic             req_valid,
    input logic [1:0]       req_op,
    input logic [31:0]      req_addr,
    input logic             fill_valid,
    input logic [3:0]       hit_vec,
    input logic [3:0]       vld_vec,
    input logic [1:0]       victim,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             fill_req,
    input logic             wb_req,
    input logic [IDX_W-1:0] wb_index
);

    // R3
    one_hit_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
        $onehot0(hit_vec));

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
        (man_rst_n && req_valid && !fill_valid && req_op != 2'b11) |=> rsp_valid);

    // R2
    fill_blocks_req_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
        fill_valid |=> !rsp_valid);

    // R6
    invalid_first_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
        !(&vld_vec) |-> !vld_vec[victim]);

    // R7
    wb_on_miss_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
        wb_req |-> (fill_req && !rsp_hit && rsp_valid));

    // R7
    wb_index_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
        wb_req |-> (wb_index == $past(req_addr[OFF_W+IDX_W-1:OFF_W])));

    // R8
    inval_quiet_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
        (man_rst_n && req_valid && !fill_valid && req_op == 2'b10) |=> (!fill_req && !wb_req));

    // R9
    man_rst_quiet_chk: assert property (@(posedge clk) disable iff (!por_rst_n)
        !man_rst_n |=> !rsp_valid);

endmodule

bind cache_dir4 cache_dir4_chk #(
    .IDX_W (IDX_W),
    .OFF_W (OFF_W)
) chk_i (
    .clk        (clk),
    .por_rst_n  (por_rst_n),
    .man_rst_n  (man_rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .fill_valid (fill_valid),
    .hit_vec    (hit_vec),
    .vld_vec    (vld_vec),
    .victim     (victim),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .fill_req   (fill_req),
    .wb_req     (wb_req),
    .wb_index   (wb_index)
);

// File: tb/cache_dir4_tb_top.sv
// Self-checking bench: vector table walk, then directed reset/corner tests.
module cache_dir4_tb_top;

    logic        clk = 1'b0;
    logic        por_rst_n = 1'b0;
    logic        man_rst_n = 1'b1;
    logic        wb_mode = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b11;
    logic [31:0] req_addr = '0;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_addr = '0;
    logic [1:0]  fill_way = '0;
    logic        rsp_valid, rsp_hit, rsp_dirty, fill_req, wb_req;
    logic [1:0]  rsp_way;
    logic [21:0] wb_tag;
    logic [7:0]  wb_index;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;   // 250 MHz

    cache_dir4 dut_i (
        .clk (clk), .por_rst_n (por_rst_n), .man_rst_n (man_rst_n),
        .wb_mode (wb_mode), .req_valid (req_valid), .req_op (req_op),
        .req_addr (req_addr), .fill_valid (fill_valid), .fill_addr (fill_addr),
        .fill_way (fill_way), .rsp_valid (rsp_valid), .rsp_hit (rsp_hit),
        .rsp_way (rsp_way), .rsp_dirty (rsp_dirty), .fill_req (fill_req),
        .wb_req (wb_req), .wb_tag (wb_tag), .wb_index (wb_index)
    );

    typedef struct packed {
        logic        is_fill;
        logic [1:0]  op;
        logic [31:0] addr;
        logic [1:0]  fway;
        logic        e_hit;
        logic [1:0]  e_way;
        logic        e_dirty;
        logic        e_fill;
        logic        e_wb;
        logic [21:0] e_tag;
        logic [3:0]  rq;
    } vec_t;

    localparam logic [31:0] A0 = 32'h0000_1050, A1 = 32'h0000_2050,
                            A2 = 32'h0000_3050, A3 = 32'h0000_4050,
                            A4 = 32'h0000_5050, A5 = 32'h0000_6050,
                            A6 = 32'h0000_7050;

    // {fill?, op, addr, fill way, hit, way, dirty, fill_req, wb_req, wb tag, req}
    localparam vec_t VEC [19] = '{
        '{1'b0, 2'b00, A0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 22'd0, 4'd7},  // R7 cold miss
        '{1'b1, 2'b11, A0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 22'd0, 4'd2},  // R2 fill cycle
        '{1'b0, 2'b00, A0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 22'd0, 4'd5},  // R5
        '{1'b0, 2'b01, A0, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 22'd0, 4'd4},  // R4
        '{1'b0, 2'b00, 32'hE000_1050, 2'd0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 22'd0, 4'd10}, // R10
        '{1'b0, 2'b00, A1, 2'd0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 22'd0, 4'd6},  // R6 invalid first
        '{1'b1, 2'b11, A1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 22'd0, 4'd2},
        '{1'b1, 2'b11, A2, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 22'd0, 4'd2},
        '{1'b1, 2'b11, A3, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 22'd0, 4'd2},
        '{1'b0, 2'b00, A4, 2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 22'd4, 4'd7},  // R7 dirty victim
        '{1'b0, 2'b00, A1, 2'd0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 22'd0, 4'd6},
        '{1'b1, 2'b11, A4, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 22'd0, 4'd2},
        '{1'b0, 2'b00, A5, 2'd0, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 22'd0, 4'd6},  // R6 oldest
        '{1'b0, 2'b10, A2, 2'd0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 22'd0, 4'd8},  // R8 hit
        '{1'b0, 2'b00, A2, 2'd0, 1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 22'd0, 4'd8},  // R8 cleared
        '{1'b0, 2'b10, A6, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 22'd0, 4'd8},  // R8 miss
        '{1'b0, 2'b00, A1, 2'd0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 22'd0, 4'd8},
        '{1'b0, 2'b00, A3, 2'd0, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 22'd0, 4'd3},  // R3
        '{1'b0, 2'b00, A4, 2'd0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 22'd0, 4'd5}   // R5 dirty cleared
    };

    task automatic check_bits(input int rq, input string what,
                              input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Compares {valid,hit,way,dirty,fill_req,wb_req}.
    task automatic check_rsp(input int rq, input string what, input logic v,
                             input logic h, input logic [1:0] w, input logic d,
                             input logic f, input logic b);
        check_bits(rq, what, {25'd0, rsp_valid, rsp_hit, rsp_way, rsp_dirty, fill_req, wb_req},
                   {25'd0, v, h, w, d, f, b});
    endtask

    task automatic issue(input logic [1:0] op, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'b11;
    endtask

    task automatic do_fill(input logic [31:0] a, input logic [1:0] w);
        @(negedge clk);
        fill_valid = 1'b1; fill_addr = a; fill_way = w;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por_rst_n = 1'b1;
        // R1 reset state
        check_rsp(1, "reset outputs", 0, 0, 2'd0, 0, 0, 0);

        for (int i = 0; i < 19; i++) begin
            if (VEC[i].is_fill) begin
                do_fill(VEC[i].addr, VEC[i].fway);
                check_rsp(VEC[i].rq, $sformatf("vec %0d fill", i), 0, 0, 2'd0, 0, 0, 0);
            end else begin
                issue(VEC[i].op, VEC[i].addr);
                check_rsp(VEC[i].rq, $sformatf("vec %0d", i), 1, VEC[i].e_hit, VEC[i].e_way,
                          VEC[i].e_dirty, VEC[i].e_fill, VEC[i].e_wb);
                if (VEC[i].e_wb) begin
                    check_bits(VEC[i].rq, "wb_tag", {10'd0, wb_tag}, {10'd0, VEC[i].e_tag});
                    check_bits(VEC[i].rq, "wb_index", {24'd0, wb_index},
                               {24'd0, VEC[i].addr[11:4]});
                end
            end
        end

        // R4 write-through keeps dirty clear
        wb_mode = 1'b0;
        issue(2'b01, A3);
        check_rsp(4, "wt write", 1, 1, 2'd3, 0, 0, 0);
        issue(2'b00, A3);
        check_rsp(4, "wt dirty kept 0", 1, 1, 2'd3, 0, 0, 0);
        wb_mode = 1'b1;

        // R2 request dropped in a fill cycle
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b00; req_addr = A1;
        fill_valid = 1'b1; fill_addr = 32'h0000_1070; fill_way = 2'd1;
        @(negedge clk);
        req_valid = 1'b0; req_op = 2'b11; fill_valid = 1'b0;
        check_rsp(2, "req with fill", 0, 0, 2'd0, 0, 0, 0);
        issue(2'b00, 32'h0000_1070);
        check_rsp(5, "fill other set", 1, 1, 2'd1, 0, 0, 0);

        // R9 manual reset keeps contents
        issue(2'b01, A4);
        check_rsp(4, "mark A4", 1, 1, 2'd0, 0, 0, 0);
        @(negedge clk);
        man_rst_n = 1'b0;
        req_valid = 1'b1; req_op = 2'b10; req_addr = A4;
        @(negedge clk);
        check_rsp(9, "during manual reset", 0, 0, 2'd0, 0, 0, 0);
        @(negedge clk);
        man_rst_n = 1'b1; req_valid = 1'b0; req_op = 2'b11;
        issue(2'b00, A4);
        check_rsp(9, "after manual reset", 1, 1, 2'd0, 1, 0, 0);

        // R1 power-on reset clears valid/dirty
        @(negedge clk);
        por_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        por_rst_n = 1'b1;
        check_rsp(1, "por outputs", 0, 0, 2'd0, 0, 0, 0);
        issue(2'b00, A4);
        check_rsp(1, "por invalid", 1, 0, 2'd0, 0, 1, 0);

        // R6 age order in set 9, filled as way 3,2,1,0
        for (int k = 3; k >= 0; k--)
            do_fill(32'h0000_0090 | ((k + 1) << 12), 2'(k));
        issue(2'b00, 32'h0000_8090);
        check_rsp(6, "lru victim 3", 1, 0, 2'd3, 0, 1, 0);
        issue(2'b00, 32'h0000_4090);
        check_rsp(6, "touch way 3", 1, 1, 2'd3, 0, 0, 0);
        issue(2'b00, 32'h0000_8090);
        check_rsp(6, "lru victim 2", 1, 0, 2'd2, 0, 1, 0);
        issue(2'b00, 32'h0000_2090);
        check_rsp(6, "touch way 1", 1, 1, 2'd1, 0, 0, 0);
        issue(2'b00, 32'h0000_3090);
        check_rsp(6, "touch way 2", 1, 1, 2'd2, 0, 0, 0);
        issue(2'b00, 32'h0000_8090);
        check_rsp(6, "lru victim 0", 1, 0, 2'd0, 0, 1, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule